// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block is an eight-bit shift chain that takes a word in parallel and hands it out one bit at a time. A low level on the load control copies the parallel word into every bit of the chain and keeps copying it for as long as the control stays low, so the chain follows the parallel inputs throughout the load period. With the load control high, each rising edge of the shift clock moves the chain one place toward the top bit, takes the serial input into the bottom bit, and presents the top bit on the serial output and its inverse on a second output.

The shift clock is not a pin of its own. It is the logical OR of two clock pins, which is the same signal as the inverted output of a two-input NOR on those pins. Either pin can therefore clock the chain, and either can block the other by being held high. All pins are sampled by a free-running system clock, and a shift edge is recognised when the OR of the two sampled clock pins was 0 at one sample and is 1 at the next. The register reacts on the second system clock edge after a pin changes.

Top module: `piso_chain`

## Requirements
- R1: After reset every bit of the chain is 0, `ser_out` is 0, `ser_out_n` is 1, and the stored shift-clock history is 0.
- R2: While `ld_n` is 0, bit i of the chain takes `par_in[i]`, whatever the clock pins do, so `ser_out` shows `par_in[W-1]`.
- R3: While `ld_n` stays 0, a change on `par_in` passes into the chain, so the chain tracks `par_in` through the whole load period.
- R4: With `ld_n` at 1, each shift edge moves bit i to bit i+1, takes `ser_in` into bit 0 and drops the old top bit; `ser_out` is bit W-1.
- R5: `sclk_a` and `sclk_b` are interchangeable: a rising edge on either one, with the other low, produces one shift.
- R6: While one clock pin is held high, edges on the other pin produce no shift.
- R7: A rising edge on one clock pin while the other pin is low produces exactly one shift, the same as a clock edge.
- R8: A rising edge on one clock pin while the other pin is already high produces no shift.
- R9: A shift edge that arrives while `ld_n` is 0 is discarded: it is not applied later when `ld_n` returns to 1.
- R10: `ser_out_n` always equals the inverse of `ser_out`.
- R11: Every pin is sampled on the rising edge of `clk`; the chain and outputs change on the second rising edge of `clk` after a pin change and hold their old value after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| par_in | input | W | Parallel word, bit i loads chain bit i |
| ld_n | input | 1 | Active-low load control; 0 loads, 1 allows shifting |
| ser_in | input | 1 | Serial data entering bit 0 on a shift |
| sclk_a | input | 1 | First shift-clock pin |
| sclk_b | input | 1 | Second shift-clock pin, equivalent to the first |
| ser_out | output | 1 | Top bit of the chain |
| ser_out_n | output | 1 | Inverse of the top bit |

## Verification
The hardest situation to reach is the one where a clock pin rises while the other pin is already high, because it must look exactly like a valid edge on that pin yet leave the chain untouched; the stimulus first raises one pin to cause a shift, then raises the second while the first stays high, toggles the first under that inhibit, and only then releases and re-raises the second pin on its own, shifting out afterwards to prove no stray shift slipped in. A second awkward case is an edge arriving during a load, which the stimulus creates by raising a clock pin with `ld_n` low and then releasing `ld_n` with the pin still high, so a deferred shift would show up as a misplaced bit in the following shift-out.

// File: rtl/piso_pkg.sv
package piso_pkg;

  typedef enum logic [1:0] {
    CHAIN_HOLD  = 2'd0,
    CHAIN_LOAD  = 2'd1,
    CHAIN_SHIFT = 2'd2
  } chain_op_e;

  // Load overrides everything; a shift needs load inactive and an edge.
  function automatic chain_op_e pick_op(input logic load_n, input logic edge_seen);
    if (!load_n)
      return CHAIN_LOAD;
    else if (edge_seen)
      return CHAIN_SHIFT;
    else
      return CHAIN_HOLD;
  endfunction

endpackage

// File: rtl/piso_rst_sync.sv
module piso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sync_q <= '0;
    else
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/piso_in_sample.sv
module piso_in_sample #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] par_in,
  input  logic         ld_n,
  input  logic         ser_in,
  input  logic         sclk_a,
  input  logic         sclk_b,
  output logic [W-1:0] par_q,
  output logic         ld_n_q,
  output logic         ser_q,
  output logic         a_q,
  output logic         b_q
);
  localparam int BUS_W = W + 4;

  logic [BUS_W-1:0] bus_d;
  logic [BUS_W-1:0] bus_q;
  logic             smp_en;

  always_comb begin
    smp_en = 1'b1;
    bus_d  = {par_in, ld_n, ser_in, sclk_a, sclk_b};
  end

  // Load control resets to 1 so no load is seen while reset releases.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_q <= {{W{1'b0}}, 1'b1, 3'b000};
    else if (smp_en)
      bus_q <= bus_d;
  end

  assign par_q  = bus_q[BUS_W-1:4];
  assign ld_n_q = bus_q[3];
  assign ser_q  = bus_q[2];
  assign a_q    = bus_q[1];
  assign b_q    = bus_q[0];
endmodule

// File: rtl/piso_edge_det.sv
module piso_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic rise
);
  logic comb_clk;
  logic prev_q;
  logic prev_d;
  logic hist_en;

  // OR of the pins equals the inverted two-input NOR.
  always_comb begin
    comb_clk = ~(~(a | b));
    prev_d   = comb_clk;
    hist_en  = 1'b1;
    rise     = comb_clk & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prev_q <= 1'b0;
    else if (hist_en)
      prev_q <= prev_d;
  end
endmodule

// File: rtl/piso_shreg.sv
module piso_shreg
  import piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         shift_edge,
  input  logic [W-1:0] par,
  input  logic         ser,
  output logic [W-1:0] q
);
  chain_op_e    op;
  logic [W-1:0] shifted;
  logic [W-1:0] q_d;
  logic         q_en;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_link
      if (i == 0) begin : g_head
        assign shifted[i] = ser;
      end else begin : g_body
        assign shifted[i] = q[i-1];
      end
    end
  endgenerate

  always_comb begin
    op   = pick_op(load_n, shift_edge);
    q_en = (op != CHAIN_HOLD);
    case (op)
      CHAIN_LOAD:  q_d = par;
      CHAIN_SHIFT: q_d = shifted;
      default:     q_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (q_en)
      q <= q_d;
  end
endmodule

// File: rtl/piso_chain.sv
module piso_chain #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] par_in,
  input  logic         ld_n,
  input  logic         ser_in,
  input  logic         sclk_a,
  input  logic         sclk_b,
  output logic         ser_out,
  output logic         ser_out_n
);
  logic         rst_n_s;
  logic [W-1:0] par_q;
  logic         ld_n_q;
  logic         ser_q;
  logic         a_q;
  logic         b_q;
  logic         shift_edge;
  logic [W-1:0] chain_q;

  piso_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  piso_in_sample #(.W(W)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .par_in (par_in),
    .ld_n   (ld_n),
    .ser_in (ser_in),
    .sclk_a (sclk_a),
    .sclk_b (sclk_b),
    .par_q  (par_q),
    .ld_n_q (ld_n_q),
    .ser_q  (ser_q),
    .a_q    (a_q),
    .b_q    (b_q)
  );

  piso_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n_s),
    .a     (a_q),
    .b     (b_q),
    .rise  (shift_edge)
  );

  piso_shreg #(.W(W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_n     (ld_n_q),
    .shift_edge (shift_edge),
    .par        (par_q),
    .ser        (ser_q),
    .q          (chain_q)
  );

  assign ser_out   = chain_q[W-1];
  assign ser_out_n = ~chain_q[W-1];
endmodule

// File: rtl/piso_chain_chk.sv
module piso_chain_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n_s,
  input logic [W-1:0] par_q,
  input logic         ld_n_q,
  input logic         ser_q,
  input logic         a_q,
  input logic         b_q,
  input logic         shift_edge,
  input logic [W-1:0] chain_q,
  input logic         ser_out,
  input logic         ser_out_n
);
  // R2 / R3: an active sampled load puts the sampled word in the chain.
  assert_load_copies_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ld_n_q |=> chain_q == $past(par_q));

  // R4: a shift edge with load inactive moves the chain up by one.
  assert_shift_moves_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ld_n_q && shift_edge) |=> chain_q == {$past(chain_q[W-2:0]), $past(ser_q)});

  // R9: with load inactive and no edge the chain keeps its value.
  assert_hold_no_edge_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ld_n_q && !shift_edge) |=> $stable(chain_q));

  // R6: a pin held high across two samples blocks any edge.
  assert_inhibit_a_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (a_q && $past(a_q)) |-> !shift_edge);

  assert_inhibit_b_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (b_q && $past(b_q)) |-> !shift_edge);

  // R8: a pin rising while the other was already high is no edge.
  assert_late_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(b_q) && $past(a_q)) |-> !shift_edge);

  // R10: outputs are complementary.
  assert_complement_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    ser_out_n != ser_out);
endmodule

bind piso_chain piso_chain_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .par_q      (par_q),
  .ld_n_q     (ld_n_q),
  .ser_q      (ser_q),
  .a_q        (a_q),
  .b_q        (b_q),
  .shift_edge (shift_edge),
  .chain_q    (chain_q),
  .ser_out    (ser_out),
  .ser_out_n  (ser_out_n)
);

// File: tb/piso_chain_bench.sv
`timescale 1ns/1ps
module piso_chain_bench;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] par_in;
  logic         ld_n;
  logic         ser_in;
  logic         sclk_a;
  logic         sclk_b;
  logic         ser_out;
  logic         ser_out_n;

  int total;
  int bad;
  bit done;

  bit    exp_q[$];
  string tag_q[$];

  logic [W-1:0] model;
  bit           prev_or;

  piso_chain #(.W(W)) u_piso_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_in    (par_in),
    .ld_n      (ld_n),
    .ser_in    (ser_in),
    .sclk_a    (sclk_a),
    .sclk_b    (sclk_b),
    .ser_out   (ser_out),
    .ser_out_n (ser_out_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit got, input bit exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  // Driver: applies one pin setting, updates the model, queues expectations.
  task automatic step(input bit a, input bit b, input bit ldn,
                      input logic [W-1:0] p, input bit si, input string tag);
    bit old_top;
    @(negedge clk);
    sclk_a = a; sclk_b = b; ld_n = ldn; par_in = p; ser_in = si;
    old_top = model[W-1];
    if (!ldn)
      model = p;
    else if ((a | b) && !prev_or)
      model = {model[W-2:0], si};
    prev_or = a | b;
    @(posedge clk);
    exp_q.push_back(old_top);
    tag_q.push_back({"R11 first edge: ", tag});
    @(posedge clk);
    exp_q.push_back(model[W-1]);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares queued expectations with the outputs.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(ser_out, e, t);
        check(ser_out_n, ~e, {"R10 ", t});
      end
    end
  end

  // Eight clean shifts on pin a (R4) with a given serial pattern.
  task automatic shift_out_a(input logic [W-1:0] si_pat, input string tag);
    for (int k = 0; k < W; k++) begin
      step(1'b1, 1'b0, 1'b1, 8'h00, si_pat[k], tag);
      step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, tag);
    end
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    model = '0; prev_or = 0;
    rst_n = 1'b0; par_in = '0; ld_n = 1'b1; ser_in = 1'b0;
    sclk_a = 1'b0; sclk_b = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ser_out, 1'b0, "R1 reset ser_out");
    check(ser_out_n, 1'b1, "R1 reset ser_out_n");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(ser_out, 1'b0, "R1 after release ser_out");
    check(ser_out_n, 1'b1, "R10 after release ser_out_n");

    // R2 load, R3 transparency while held
    step(1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, "R2 load A5");
    step(1'b0, 1'b0, 1'b0, 8'h35, 1'b0, "R3 track 35");
    step(1'b0, 1'b0, 1'b0, 8'hC3, 1'b0, "R3 track C3");
    // R2 clocks ignored while loading, R9 edge discarded
    step(1'b1, 1'b0, 1'b0, 8'h6B, 1'b1, "R2 load over clock");
    step(1'b1, 1'b0, 1'b1, 8'h00, 1'b1, "R9 no deferred shift");
    step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R9 idle");
    // chain must still hold 6B exactly; shift it out with pattern
    shift_out_a(8'b1001_0110, "R4 shift out 6B");

    // R5 shifts on pin b
    step(1'b0, 1'b0, 1'b0, 8'h96, 1'b0, "R2 load 96");
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b1, 1'b1, 8'h00, k[0], "R5 shift on b");
      step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R5 idle");
    end

    // Inhibit sequence
    step(1'b1, 1'b0, 1'b1, 8'h00, 1'b1, "R7 a rises alone");
    step(1'b1, 1'b1, 1'b1, 8'h00, 1'b0, "R8 b rises with a high");
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, "R6 a falls under b");
    step(1'b1, 1'b1, 1'b1, 8'h00, 1'b1, "R6 a rises under b");
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, "R6 a falls under b");
    step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R6 b released");
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b1, "R7 b rises with a low");
    step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R7 idle");
    shift_out_a(8'b0101_1100, "R4 shift out after inhibit");

    repeat (4) @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule